// File: doc/BRIEF.md
# Row-Buffered Burst Read Memory

This block is a synthesizable storage array laid out as rows of column words, read in short bursts through a row-wide buffer. A requester pulses a request strobe together with a start address. The block takes the upper address bits as the row and the lower bits as the column. On a row miss it first copies the whole row into its buffer. It then returns consecutive column words, one per clock, and steps the column pointer on its own, so the requester presents only the start address.

A request to the row that is already buffered skips the row copy and gets its first word one cycle earlier. A burst never runs past the last column of its row. When it would, it stops on that column, marks that word as the final one and sets a sticky truncation flag. A separate single-word write port fills and updates the contents. A write to the buffered row also updates the buffer, so later beats return the new data.

Top module: `burst_row_mem`

## Requirements
- R1: The request address splits into row = addr[AW-1:CW] and column = addr[CW-1:0], with CW = log2(COLS). The first beat of a burst carries the word stored at that row and column. The write address splits the same way.
- R2: On a row miss, the first beat is valid in the second cycle after the cycle in which the request is sampled, and valid is low in the cycle between. The first request after reset is always a row miss.
- R3: On a row hit (the requested row equals the row opened by the previous burst), the first beat is valid in the cycle right after the request is sampled.
- R4: A burst delivers up to BURST (default 4) words from columns A, A+1, A+2, A+3 on consecutive cycles with valid held high. Last is high only on the final word. Valid is low when no word is delivered.
- R5: A burst starting at column A ends on column COLS-1 when A+BURST-1 would exceed it. That word carries last, and the truncation flag rises with it and stays high until reset. A full-length burst that ends exactly on column COLS-1 does not set the flag.
- R6: Busy is high from the cycle after a request is accepted through the cycle of the last beat, and low otherwise. A request sampled while busy is high is ignored: it changes neither the current burst nor the open row.
- R7: A write takes effect at the clock edge on which it is sampled. Beats produced on later edges return the new value, including beats from the buffered row. A beat produced on the same edge as a write to its word returns the previous value.
- R8: After reset, valid, last, busy and the truncation flag are low, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Burst request strobe |
| addr_i | input | AW | Burst start address {row, column} |
| wr_en_i | input | 1 | Single-word write enable |
| wr_addr_i | input | AW | Write address {row, column} |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Burst data word |
| rd_valid_o | output | 1 | Burst data valid |
| rd_last_o | output | 1 | Final word of the burst |
| busy_o | output | 1 | Burst in progress |
| trunc_o | output | 1 | Sticky flag: a burst was cut at a row end |

## Verification
The write port and the burst stream can act in the same cycle. A write can land on the word a beat is reading, on a word of the open row that a later beat will read, or during the row-copy cycle of a miss. The bench places writes at chosen cycles inside directed bursts and at random cycles inside random bursts. It judges each beat against a model that applies a write only after the beat of the same edge has been compared. The same random bursts also carry ignored requests sent while busy is high, so any row hit or miss they caused would show up as a wrong latency in the next burst.

// File: rtl/brm_pkg.sv
package brm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACT   = 2'd1,
        ST_BURST = 2'd2
    } brm_state_e;
endpackage

// File: rtl/brm_addr_split.sv
module brm_addr_split #(
    parameter int RW = 4,
    parameter int CW = 4
) (
    input  logic [RW+CW-1:0] addr,
    output logic [RW-1:0]    row,
    output logic [CW-1:0]    col
);
    assign row = addr[RW+CW-1:CW];
    assign col = addr[CW-1:0];
endmodule

// File: rtl/brm_array.sv
module brm_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 32,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [RW-1:0]      wr_row,
    input  logic [CW-1:0]      wr_col,
    input  logic [DW-1:0]      wr_data,
    input  logic [RW-1:0]      rd_row,
    output logic [COLS*DW-1:0] rd_line
);
    logic [DW-1:0] mem [ROWS*COLS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wr_row, wr_col}] <= wr_data;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_line
        assign rd_line[c*DW +: DW] = mem[{rd_row, CW'(c)}];
    end
endmodule

// File: rtl/brm_burst_ctrl.sv
module brm_burst_ctrl
    import brm_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int DW    = 32,
    parameter int BURST = 4,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int BW   = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [RW-1:0]      req_row,
    input  logic [CW-1:0]      req_col,
    input  logic               wr_en,
    input  logic [RW-1:0]      wr_row,
    input  logic [CW-1:0]      wr_col,
    input  logic [DW-1:0]      wr_data,
    output logic [RW-1:0]      arr_row,
    input  logic [COLS*DW-1:0] arr_line,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               rd_last,
    output logic               busy,
    output logic               trunc
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);
    localparam logic [CW-1:0] LAST_COL  = CW'(COLS - 1);

    typedef struct packed {
        brm_state_e                st;
        logic                      open;
        logic [RW-1:0]             orow;
        logic [CW-1:0]             col;
        logic [BW-1:0]             beat;
        logic [COLS-1:0][DW-1:0]   rbuf;
        logic [DW-1:0]             data;
        logic                      valid;
        logic                      last;
        logic                      busy;
        logic                      trunc;
    } ctl_t;

    ctl_t                    ctl_d, ctl_q;
    logic [COLS-1:0][DW-1:0] line_w;
    logic                    accept, hit, emit, end_row, end_len;
    logic [CW-1:0]           emit_col;
    logic [BW-1:0]           emit_beat;
    logic [DW-1:0]           src_word;

    assign line_w  = arr_line;
    assign arr_row = ctl_q.orow;
    assign accept  = (ctl_q.st == ST_IDLE) && req && !ctl_q.busy;
    assign hit     = ctl_q.open && (ctl_q.orow == req_row);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        ctl_d.last  = 1'b0;
        emit        = 1'b0;
        emit_col    = ctl_q.col;
        emit_beat   = ctl_q.beat;
        src_word    = ctl_q.rbuf[ctl_q.col];
        end_row     = 1'b0;
        end_len     = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.busy = 1'b0;
                if (accept) begin
                    ctl_d.busy = 1'b1;
                    if (hit) begin
                        emit      = 1'b1;
                        emit_col  = req_col;
                        emit_beat = '0;
                        src_word  = ctl_q.rbuf[req_col];
                    end else begin
                        ctl_d.st   = ST_ACT;
                        ctl_d.open = 1'b0;
                        ctl_d.orow = req_row;
                        ctl_d.col  = req_col;
                        ctl_d.beat = '0;
                    end
                end
            end
            ST_ACT: begin
                ctl_d.rbuf = line_w;
                ctl_d.open = 1'b1;
                emit       = 1'b1;
                src_word   = line_w[ctl_q.col];
            end
            ST_BURST: begin
                emit = 1'b1;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        if (emit) begin
            ctl_d.valid = 1'b1;
            ctl_d.data  = src_word;
            end_row     = (emit_col == LAST_COL);
            end_len     = (emit_beat == LAST_BEAT);
            if (end_row || end_len) begin
                ctl_d.last = 1'b1;
                ctl_d.st   = ST_IDLE;
                if (end_row && !end_len) begin
                    ctl_d.trunc = 1'b1;
                end
            end else begin
                ctl_d.st   = ST_BURST;
                ctl_d.col  = emit_col + CW'(1);
                ctl_d.beat = emit_beat + BW'(1);
            end
        end

        // keep the row buffer coherent with the array
        if (wr_en && ctl_d.open && (wr_row == ctl_d.orow)) begin
            ctl_d.rbuf[wr_col] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data  = ctl_q.data;
    assign rd_valid = ctl_q.valid;
    assign rd_last  = ctl_q.last;
    assign busy     = ctl_q.busy;
    assign trunc    = ctl_q.trunc;

    p_miss_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> !rd_valid);
    p_miss_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> ##1 rd_valid);
    p_hit_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> rd_valid);
    p_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid);
    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BURST) |-> (ctl_q.col != '0));
    p_trunc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trunc |=> trunc);
    p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && busy) |=> $stable(ctl_q.orow));
endmodule

// File: rtl/burst_row_mem.sv
module burst_row_mem #(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int DW    = 32,
    parameter int BURST = 4,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int AW   = RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic          rd_last_o,
    output logic          busy_o,
    output logic          trunc_o
);
    logic [RW-1:0]      req_row, wr_row, arr_row;
    logic [CW-1:0]      req_col, wr_col;
    logic [COLS*DW-1:0] arr_line;

    brm_addr_split #(.RW(RW), .CW(CW)) u_req_split (
        .addr(addr_i), .row(req_row), .col(req_col)
    );

    brm_addr_split #(.RW(RW), .CW(CW)) u_wr_split (
        .addr(wr_addr_i), .row(wr_row), .col(wr_col)
    );

    brm_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
        .clk     (clk),
        .we      (wr_en_i),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data_i),
        .rd_row  (arr_row),
        .rd_line (arr_line)
    );

    brm_burst_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .BURST(BURST)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_i),
        .req_row  (req_row),
        .req_col  (req_col),
        .wr_en    (wr_en_i),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data_i),
        .arr_row  (arr_row),
        .arr_line (arr_line),
        .rd_data  (rd_data_o),
        .rd_valid (rd_valid_o),
        .rd_last  (rd_last_o),
        .busy     (busy_o),
        .trunc    (trunc_o)
    );
endmodule

// File: tb/tb_burst_row_mem.sv
`timescale 1ns/1ps
module tb_burst_row_mem;
    localparam int ROWS  = 16;
    localparam int COLS  = 16;
    localparam int DW    = 32;
    localparam int BURST = 4;
    localparam int CW    = 4;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_i;
    logic [AW-1:0] addr_i;
    logic          wr_en_i;
    logic [AW-1:0] wr_addr_i;
    logic [DW-1:0] wr_data_i;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o, rd_last_o, busy_o, trunc_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;

    logic [DW-1:0] model [ROWS*COLS];
    bit            open_m  = 1'b0;
    int            orow_m  = 0;
    bit            trunc_m = 1'b0;

    always #4 clk = ~clk;

    burst_row_mem #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .BURST(BURST)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o),
        .busy_o(busy_o), .trunc_o(trunc_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int beats_for(input int col);
        return (COLS - col < BURST) ? (COLS - col) : BURST;
    endfunction

    // one burst; force_k > 0 places a write before edge force_k
    task automatic run_burst(input int row, input int col, input int force_k,
                             input int f_addr, input bit rnd);
        bit hit;
        int lat, nb, lastk, b, idx;
        bit exp_valid;
        logic [DW-1:0] exp_data;
        string ltag, dtag;
        bit wrote;
        hit   = open_m && (orow_m == row);
        lat   = hit ? 1 : 2;
        nb    = beats_for(col);
        lastk = lat + nb - 1;
        ltag  = hit ? "R3" : "R2";
        wrote = 1'b0;
        for (int k = 1; k <= lastk + 1; k++) begin
            @(negedge clk);
            req_i   = (k == 1);
            addr_i  = AW'(row * COLS + col);
            wr_en_i = 1'b0;
            if (k > 1 && rnd && $urandom_range(0, 2) == 0) begin
                req_i  = 1'b1;   // must be ignored: busy is high (R6)
                addr_i = AW'($urandom);
            end
            if (k == force_k) begin
                wr_en_i   = 1'b1;
                wr_addr_i = AW'(f_addr);
                wr_data_i = $urandom;
            end else if (rnd && $urandom_range(0, 2) == 0) begin
                wr_en_i   = 1'b1;
                wr_addr_i = ($urandom_range(0, 1) == 0) ?
                            AW'(row * COLS + $urandom_range(0, COLS - 1)) : AW'($urandom);
                wr_data_i = $urandom;
            end
            b         = k - lat;
            exp_valid = (b >= 0) && (b < nb);
            exp_data  = '0;
            if (exp_valid) begin
                idx      = row * COLS + col + b;
                exp_data = model[idx];
            end
            @(posedge clk);
            #1;
            chk(rd_valid_o == exp_valid, ltag, "valid timing", 64'(rd_valid_o), 64'(exp_valid));
            chk(busy_o == (k <= lastk), "R6", "busy", 64'(busy_o), 64'(k <= lastk));
            chk(rd_last_o == (exp_valid && b == nb - 1), (nb < BURST) ? "R5" : "R4",
                "last", 64'(rd_last_o), 64'(exp_valid && b == nb - 1));
            if (exp_valid) begin
                dtag = wrote ? "R7" : ((b == 0) ? "R1" : "R4");
                chk(rd_data_o === exp_data, dtag, "beat data", 64'(rd_data_o), 64'(exp_data));
            end
            if (wr_en_i) begin
                model[wr_addr_i] = wr_data_i;
                if (int'(wr_addr_i) / COLS == row) wrote = 1'b1;
            end
        end
        @(negedge clk);
        req_i   = 1'b0;
        wr_en_i = 1'b0;
        open_m  = 1'b1;
        orow_m  = row;
        if (nb < BURST) trunc_m = 1'b1;
        chk(trunc_o == trunc_m, "R5", "trunc flag", 64'(trunc_o), 64'(trunc_m));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        rst_n = 1'b0; req_i = 1'b0; addr_i = '0;
        wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        chk(!rd_valid_o && !rd_last_o && !busy_o && !trunc_o, "R8", "reset outputs",
            {60'd0, rd_valid_o, rd_last_o, busy_o, trunc_o}, 64'd0);

        // preload all words; a {row,col} tag in the high bits checks the split (R1)
        for (int a = 0; a < ROWS * COLS; a++) begin
            @(negedge clk);
            wr_en_i   = 1'b1;
            wr_addr_i = AW'(a);
            wr_data_i = {8'(a / COLS), 8'(a % COLS), 16'($urandom)};
            model[a]  = wr_data_i;
        end
        @(negedge clk);
        wr_en_i = 1'b0;
        @(posedge clk); #1;
        chk(!rd_valid_o && !busy_o, "R6", "idle during preload", 64'(rd_valid_o), 64'd0);

        // first request after reset is a miss (R2), then a hit in the same row (R3)
        run_burst(3, 2, 0, 0, 1'b0);
        run_burst(3, 5, 0, 0, 1'b0);
        // full burst ending exactly on the last column leaves trunc low (R5)
        run_burst(7, 12, 0, 0, 1'b0);
        // write to a later beat's word during the row copy cycle (R7)
        run_burst(9, 4, 2, 9 * COLS + 6, 1'b0);
        // write on the same edge as beat 1 reads that word: old value (R7)
        run_burst(9, 8, 2, 9 * COLS + 9, 1'b0);
        // truncated hit at column 14, then truncated miss at column 15 (R5)
        run_burst(9, 14, 0, 0, 1'b0);
        run_burst(2, 15, 0, 0, 1'b0);

        // random bursts with writes and ignored requests mixed in
        for (int n = 0; n < 300; n++) begin
            run_burst($urandom_range(0, 3), $urandom_range(0, COLS - 1), 0, 0, 1'b1);
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                @(posedge clk); #1;
                chk(!rd_valid_o && !busy_o, "R4", "idle gap", 64'(rd_valid_o), 64'd0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule